// File: doc/BRIEF.md
# Shift-Pair and Field-Extract Unit

This block evaluates one 32-bit instruction from a single major-opcode group. It handles a right shift across a register pair, where the shift amount comes either from the shift-amount register or from an immediate. It also handles a bit-field extract, with the position likewise taken from the shift-amount register or from an immediate, and with a zero-extended or sign-extended result. The caller presents the instruction word and the values of the two source registers that the word names. It also presents the current 5-bit shift-amount register. The block returns the result, the index of the register to write, and a nullify flag that comes from testing the result against a 3-bit condition.

The operation is evaluated combinationally and captured on the clock edge where the input strobe is high. All outputs are registered. If a word does not belong to this group, or if it sets bits that its sub-operation reserves, the block raises an illegal flag and leaves the earlier result, destination and nullify outputs as they were.

Top module: `shift_extract_unit`

## Requirements
- R1: After reset, result, destIdx, nullify, illegal and outValid are all zero.
- R2: A strobed word whose bits 31:26 differ from 0x34 sets illegal to 1. It leaves result, destIdx and nullify unchanged.
- R3: The sub-operation in bits 12:11 is 00 = pair shift by register amount, 01 = pair shift by immediate, 10 = extract at register position, 11 = extract at immediate position. Sub-op 00 requires bits 10:5 to be zero, sub-op 01 requires bit 10 to be zero, and sub-op 10 requires bits 9:5 to be zero. A violation acts as in R2.
- R4: A pair shift returns the low 32 bits of {hiVal, loVal} shifted right. hiVal is the register indexed by bits 20:16 and loVal is the register indexed by bits 25:21. destIdx is bits 4:0.
- R5: When bits 20:16 are zero, a pair shift uses zero as its upper word and ignores hiVal.
- R6: When bits 20:16 equal bits 25:21 and are nonzero, a pair shift is a 32-bit right rotate of loVal, and hiVal is ignored.
- R7: The register-amount pair shift shifts by sar. The immediate pair shift shifts by 31 minus bits 9:5.
- R8: An extract reads loVal, writes destIdx = bits 20:16, and has a field length of 32 minus bits 4:0. The field's lowest bit sits at 31 minus bits 9:5 for the immediate form and at 31 minus sar for the register form.
- R9: Bit 10 of an extract set means sign extension from the field's top bit. Clear means zero extension. Field bits above bit 31 read as copies of bit 31 when sign-extending and as zero otherwise.
- R10: The condition in bits 15:13 sets nullify as follows: 0 never, 1 result zero, 2 result negative, 3 result odd, 4 always, 5 result nonzero, 6 result non-negative, 7 result even.
- R11: Outputs change only one clock after a cycle with inValid high. outValid is high for exactly that one cycle, and with no strobe every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: evaluate the presented word |
| instr | input | 32 | Instruction word |
| hiVal | input | 32 | Value of register indexed by bits 20:16 |
| loVal | input | 32 | Value of register indexed by bits 25:21 |
| sar | input | 5 | Shift-amount register |
| outValid | output | 1 | One-cycle pulse after a strobe |
| result | output | 32 | Registered result |
| destIdx | output | 5 | Registered destination register index |
| nullify | output | 1 | Registered nullify flag |
| illegal | output | 1 | Registered illegal-word flag |

## Verification
Every output is due exactly one clock after the edge at which inValid is high. The bench drives a word on a falling edge, drops the strobe at the next falling edge, and checks all outputs there, half a period after the capturing edge. It also confirms that outValid falls one cycle later and that outputs hold while no strobe arrives. For illegal words, the bench compares result, destIdx and nullify against the values captured from the previous legal word.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int LEN_W  = SH_W + 1;
  localparam int COND_W = 3;

  typedef enum logic [1:0] {
    OP_PAIR_VAR = 2'b00,
    OP_PAIR_IMM = 2'b01,
    OP_EXT_VAR  = 2'b10,
    OP_EXT_IMM  = 2'b11
  } opKindE;

  typedef struct packed {
    logic              load;
    logic              legal;
    opKindE            op;
    logic [SH_W-1:0]   amount;
    logic [LEN_W-1:0]  fieldLen;
    logic              signExt;
    logic [COND_W-1:0] cond;
    logic [IDX_W-1:0]  dest;
    logic              zeroHigh;
    logic              rotate;
  } ctrlS;
endpackage

// File: rtl/sxu_ctrl.sv
module sxu_ctrl
  import sxu_pkg::*;
#(
  parameter logic [5:0] MAJOR_OP = 6'h34
) (
  input  logic              inValid,
  input  logic [DATA_W-1:0] instr,
  input  logic [SH_W-1:0]   sar,
  output ctrlS              ctrl
);
  localparam logic [SH_W-1:0] SH_MAX = SH_W'(DATA_W - 1);

  logic [5:0]       opcode;
  opKindE           subOp;
  logic             bit10;
  logic [4:0]       fImm;
  logic [4:0]       fLen;
  logic [IDX_W-1:0] idxLo;
  logic [IDX_W-1:0] idxHi;
  logic             subOk;

  always_comb begin
    opcode = instr[31:26];
    subOp  = opKindE'(instr[12:11]);
    bit10  = instr[10];
    fImm   = instr[9:5];
    fLen   = instr[4:0];
    idxLo  = instr[25:21];
    idxHi  = instr[20:16];

    unique case (subOp)
      OP_PAIR_VAR: subOk = !bit10 && (fImm == 5'd0);
      OP_PAIR_IMM: subOk = !bit10;
      OP_EXT_VAR:  subOk = (fImm == 5'd0);
      default:     subOk = 1'b1;
    endcase

    ctrl.load  = inValid;
    ctrl.legal = (opcode == MAJOR_OP) && subOk;
    ctrl.op    = subOp;

    // Position / amount: register forms use sar, immediate forms use 31 - field.
    unique case (subOp)
      OP_PAIR_VAR: ctrl.amount = sar;
      OP_PAIR_IMM: ctrl.amount = SH_MAX - fImm;
      OP_EXT_VAR:  ctrl.amount = sar ^ SH_MAX;
      default:     ctrl.amount = SH_MAX - fImm;
    endcase

    ctrl.fieldLen = LEN_W'(DATA_W) - {1'b0, fLen};
    ctrl.signExt  = subOp[1] & bit10;
    ctrl.cond     = instr[15:13];
    ctrl.dest     = subOp[1] ? idxHi : fLen;
    ctrl.zeroHigh = (idxHi == '0);
    ctrl.rotate   = (idxHi == idxLo) && (idxHi != '0);
  end
endmodule

// File: rtl/sxu_cond.sv
module sxu_cond
  import sxu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [DATA_W-1:0] value,
  output logic              hit
);
  logic isZero;
  logic isNeg;
  logic isOdd;

  always_comb begin
    isZero = (value == '0);
    isNeg  = value[DATA_W-1];
    isOdd  = value[0];
    unique case (cond)
      3'd0:    hit = 1'b0;
      3'd1:    hit = isZero;
      3'd2:    hit = isNeg;
      3'd3:    hit = isOdd;
      3'd4:    hit = 1'b1;
      3'd5:    hit = !isZero;
      3'd6:    hit = !isNeg;
      default: hit = !isOdd;
    endcase
  end
endmodule

// File: rtl/sxu_datapath.sv
module sxu_datapath
  import sxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlS              ctrl,
  input  logic [DATA_W-1:0] hiVal,
  input  logic [DATA_W-1:0] loVal,
  output logic              validQ,
  output logic [DATA_W-1:0] resultQ,
  output logic [IDX_W-1:0]  destQ,
  output logic              nullQ,
  output logic              illegalQ
);
  localparam int PAIR_W = 2 * DATA_W;

  logic [DATA_W-1:0] upperWord;
  logic [PAIR_W-1:0] pairWide;
  logic [DATA_W-1:0] pairRes;
  logic [DATA_W-1:0] shifted;
  logic [PAIR_W-1:0] maskWide;
  logic [DATA_W-1:0] fieldMask;
  logic [SH_W-1:0]   topBit;
  logic [DATA_W-1:0] extRes;
  logic [DATA_W-1:0] nextRes;
  logic              nextNull;

  // Pair shift
  always_comb begin
    if (ctrl.zeroHigh)    upperWord = '0;
    else if (ctrl.rotate) upperWord = loVal;
    else                  upperWord = hiVal;
    pairWide = {upperWord, loVal} >> ctrl.amount;
    pairRes  = pairWide[DATA_W-1:0];
  end

  // Field extract
  always_comb begin
    if (ctrl.signExt) shifted = DATA_W'($signed(loVal) >>> ctrl.amount);
    else              shifted = loVal >> ctrl.amount;
    maskWide  = (PAIR_W'(1) << ctrl.fieldLen) - PAIR_W'(1);
    fieldMask = maskWide[DATA_W-1:0];
    topBit    = SH_W'(ctrl.fieldLen - LEN_W'(1));
    extRes    = shifted & fieldMask;
    if (ctrl.signExt && shifted[topBit]) extRes = extRes | ~fieldMask;
  end

  assign nextRes = ctrl.op[1] ? extRes : pairRes;

  sxu_cond u_cond (
    .cond (ctrl.cond),
    .value(nextRes),
    .hit  (nextNull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      resultQ  <= '0;
      destQ    <= '0;
      nullQ    <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      validQ <= ctrl.load;
      if (ctrl.load) begin
        illegalQ <= !ctrl.legal;
        if (ctrl.legal) begin
          resultQ <= nextRes;
          destQ   <= ctrl.dest;
          nullQ   <= nextNull;
        end
      end
    end
  end

  assert_illegal_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.legal) |=> (illegalQ && $stable(resultQ) && $stable(destQ) && $stable(nullQ)));

  assert_cond_never_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.legal && ctrl.cond == 3'd0) |=> !nullQ);

  assert_cond_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.legal && ctrl.cond == 3'd1) |=> (nullQ == (resultQ == '0)));

  assert_cond_odd_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.legal && ctrl.cond == 3'd3) |=> (nullQ == resultQ[0]));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> (!validQ && $stable(resultQ) && $stable(destQ) && $stable(nullQ) && $stable(illegalQ)));

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> validQ);
endmodule

// File: rtl/shift_extract_unit.sv
module shift_extract_unit
  import sxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] hiVal,
  input  logic [DATA_W-1:0] loVal,
  input  logic [SH_W-1:0]   sar,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  destIdx,
  output logic              nullify,
  output logic              illegal
);
  ctrlS ctrl;

  sxu_ctrl #(.MAJOR_OP(6'h34)) u_ctrl (
    .inValid(inValid),
    .instr  (instr),
    .sar    (sar),
    .ctrl   (ctrl)
  );

  sxu_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .hiVal   (hiVal),
    .loVal   (loVal),
    .validQ  (outValid),
    .resultQ (result),
    .destQ   (destIdx),
    .nullQ   (nullify),
    .illegalQ(illegal)
  );
endmodule

// File: tb/sim_shift_extract_unit.sv
module sim_shift_extract_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] hiVal = '0;
  logic [31:0] loVal = '0;
  logic [4:0]  sar = '0;
  logic        outValid;
  logic [31:0] result;
  logic [4:0]  destIdx;
  logic        nullify;
  logic        illegal;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  shift_extract_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .hiVal(hiVal), .loVal(loVal), .sar(sar), .outValid(outValid),
    .result(result), .destIdx(destIdx), .nullify(nullify), .illegal(illegal)
  );

  typedef struct packed {
    logic [1:0]  sub;
    logic        b10;
    logic [4:0]  fImm;
    logic [4:0]  fLen;
    logic [4:0]  idxA;   // bits 25:21
    logic [4:0]  idxB;   // bits 20:16
    logic [2:0]  cond;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [4:0]  sarV;
    logic [31:0] expRes;
    logic        expNull;
  } vecS;

  localparam int NVEC = 14;
  localparam vecS VECS [NVEC] = '{
    '{2'b00,1'b0,5'd0, 5'd6, 5'd2,5'd3,3'd0,32'h11223344,32'h55667788,5'd8, 32'h44556677,1'b0},
    '{2'b01,1'b0,5'd27,5'd1, 5'd2,5'd3,3'd2,32'h0000000F,32'h12345678,5'd0, 32'hF1234567,1'b1},
    '{2'b00,1'b0,5'd0, 5'd4, 5'd5,5'd0,3'd3,32'hFFFFFFFF,32'h80000000,5'd31,32'h00000001,1'b1},
    '{2'b01,1'b0,5'd23,5'd7, 5'd7,5'd7,3'd7,32'hFFFFFFFF,32'h12345678,5'd0, 32'h78123456,1'b1},
    '{2'b00,1'b0,5'd0, 5'd9, 5'd4,5'd4,3'd5,32'h00000000,32'hAAAA5555,5'd16,32'h5555AAAA,1'b1},
    '{2'b01,1'b0,5'd0, 5'd10,5'd6,5'd8,3'd1,32'h00000001,32'h80000000,5'd0, 32'h00000003,1'b0},
    '{2'b11,1'b0,5'd23,5'd24,5'd1,5'd9,3'd6,32'h0,       32'h12AB3456,5'd0, 32'h00000034,1'b1},
    '{2'b11,1'b1,5'd15,5'd24,5'd1,5'd11,3'd2,32'h0,      32'h12AB3456,5'd0, 32'hFFFFFFAB,1'b1},
    '{2'b10,1'b0,5'd0, 5'd28,5'd3,5'd12,3'd4,32'h0,      32'h0000F5A0,5'd23,32'h00000005,1'b1},
    '{2'b10,1'b1,5'd0, 5'd31,5'd3,5'd13,3'd1,32'h0,      32'h80000000,5'd0, 32'hFFFFFFFF,1'b0},
    '{2'b11,1'b0,5'd31,5'd0, 5'd3,5'd14,3'd0,32'h0,      32'hCAFEF00D,5'd0, 32'hCAFEF00D,1'b0},
    '{2'b11,1'b1,5'd3, 5'd24,5'd3,5'd15,3'd0,32'h0,      32'h90000000,5'd0, 32'hFFFFFFF9,1'b0},
    '{2'b11,1'b0,5'd3, 5'd24,5'd3,5'd16,3'd7,32'h0,      32'h90000000,5'd0, 32'h00000009,1'b0},
    '{2'b00,1'b0,5'd0, 5'd17,5'd1,5'd2,3'd1,32'h00001234,32'h00000000,5'd0, 32'h00000000,1'b1}
  };

  function automatic string tagFor(int i);
    case (i)
      0:  return "R4 R7";
      1:  return "R7 R10";
      2:  return "R5";
      3:  return "R6";
      4:  return "R6 R7";
      5:  return "R7 R10";
      6:  return "R8";
      7:  return "R9";
      8:  return "R8 R10";
      9:  return "R8 R9";
      10: return "R8";
      11: return "R9";
      12: return "R9 R10";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [31:0] mkInstr(logic [5:0] opc, vecS v);
    return {opc, v.idxA, v.idxB, v.cond, v.sub, v.b10, v.fImm, v.fLen};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one word for one strobe cycle; return at the falling edge after capture.
  task automatic issue(logic [31:0] w, logic [31:0] h, logic [31:0] l, logic [4:0] s);
    @(negedge clk);
    instr = w; hiVal = h; loVal = l; sar = s; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] heldRes;
    logic [4:0]  heldDest;
    logic        heldNull;
    vecS         v;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result, 32'h0);
    check("R1 flags", {27'd0, outValid, nullify, illegal, destIdx == 5'd0, 1'b0}, {27'd0, 3'b000, 1'b1, 1'b0});
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      issue(mkInstr(6'h34, v), v.hi, v.lo, v.sarV);
      check({tagFor(i), " result"}, result, v.expRes);
      check({tagFor(i), " nullify"}, {31'd0, nullify}, {31'd0, v.expNull});
      check({tagFor(i), " dest"}, {27'd0, destIdx}, {27'd0, (v.sub[1] ? v.idxB : v.fLen)});
      check({tagFor(i), " illegal"}, {31'd0, illegal}, 32'd0);
      check("R11 outValid pulse", {31'd0, outValid}, 32'd1);
    end

    // R11: one cycle later outValid drops and outputs hold
    heldRes = result; heldDest = destIdx; heldNull = nullify;
    @(negedge clk);
    check("R11 outValid low", {31'd0, outValid}, 32'd0);
    instr = 32'hFFFFFFFF; loVal = 32'h12345678; hiVal = 32'h9; sar = 5'd3;
    repeat (3) @(negedge clk);
    check("R11 hold result", result, heldRes);
    check("R11 hold dest", {27'd0, destIdx}, {27'd0, heldDest});

    // R2: wrong major opcode
    v = VECS[0];
    issue(mkInstr(6'h35, v), v.hi, v.lo, v.sarV);
    check("R2 illegal", {31'd0, illegal}, 32'd1);
    check("R2 result held", result, heldRes);
    check("R2 dest held", {27'd0, destIdx}, {27'd0, heldDest});
    check("R2 nullify held", {31'd0, nullify}, {31'd0, heldNull});

    // Legal word clears illegal
    v = VECS[6];
    issue(mkInstr(6'h34, v), v.hi, v.lo, v.sarV);
    check("R2 illegal cleared", {31'd0, illegal}, 32'd0);
    heldRes = result; heldDest = destIdx; heldNull = nullify;

    // R3: register pair shift with bits 9:5 set
    v = VECS[0]; v.fImm = 5'd4;
    issue(mkInstr(6'h34, v), v.hi, v.lo, v.sarV);
    check("R3 pair-var reserved", {31'd0, illegal}, 32'd1);
    check("R3 result held", result, heldRes);
    // R3: immediate pair shift with bit 10 set
    v = VECS[1]; v.b10 = 1'b1;
    issue(mkInstr(6'h34, v), v.hi, v.lo, v.sarV);
    check("R3 pair-imm reserved", {31'd0, illegal}, 32'd1);
    check("R3 dest held", {27'd0, destIdx}, {27'd0, heldDest});
    // R3: register extract with bits 9:5 set
    v = VECS[8]; v.fImm = 5'd1;
    issue(mkInstr(6'h34, v), v.hi, v.lo, v.sarV);
    check("R3 ext-var reserved", {31'd0, illegal}, 32'd1);
    check("R3 nullify held", {31'd0, nullify}, {31'd0, heldNull});

    // R1: reset mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset result", result, 32'h0);
    check("R1 re-reset illegal", {31'd0, illegal}, 32'd0);
    rstN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule